// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block takes a processor from an accepted interrupt to the first fetch of its handler. While no entry is in progress, it looks at the pending hardware request and at any software interrupt instruction. It samples them when an instruction has just finished, or at any cycle while the core reports that a pausable instruction is running (block move, string store, multiply-accumulate). A hardware request wins entry only when interrupts are enabled and its level is strictly above the current priority level. A software interrupt instruction skips that test.

Once an entry is accepted, the block runs a fixed 18-cycle script on a single-word bus. For hardware sources it reads address zero to learn the source number and level, and tells the request logic to clear that source. It then snapshots the flag word and writes back a copy with the enable, single-step and stack-select flags cleared. It pushes the snapshot and the return address, lowers the stack pointer by four, and raises the priority level for hardware sources. Finally it reads a two-word vector and loads the program counter. The cycles in between are left free for prefetch.

The flag, program counter, stack pointer and priority-level registers live outside the block. The block reads their current values and updates them through one write strobe per register.

Top module: `irq_entry_seq`

## Requirements
- R1: Entry starts on the clock edge that samples a qualifying request while the block is idle. A hardware request (`hw_req`) qualifies only when flag bit 6 (interrupt enable) is 1, `hw_lvl` is strictly greater than `cpu_ipl`, and either `insn_done` or `insn_pausable` is high. A software request (`sw_req`) qualifies whenever `insn_done` is high, whatever the enable flag and priority level. When both qualify, the software request is taken.
- R2: `busy` stays high for exactly 18 cycles per entry. `done` pulses for one cycle in the last of them. No new entry is accepted while `busy` is high.
- R3: A hardware entry performs exactly one acknowledge read, at address 0, and it is the first bus cycle of the entry. The returned word carries the source number in bits 5:0 and the level in bits 14:12. In that same cycle `ack_clr` pulses with `ack_num` equal to the returned number. A software entry performs no acknowledge read and no `ack_clr`.
- R4: Exactly one flag write occurs per entry. It carries the pre-entry flag word with bit 6 (interrupt enable), bit 2 (single step) and bit 7 (stack select) cleared, and every other bit unchanged.
- R5: For a software entry whose number is 32 to 63, bit 7 keeps its pre-entry value. For a software entry with a number of 31 or below, bit 7 is cleared.
- R6: The entry performs two stack writes. The first goes to SP-2 and carries {PC[19:16], pre-entry flags[11:0]}. The second goes to SP-4 and carries PC[15:0]. Stack addresses are the 16-bit result zero-extended to 20 bits. SP ends at its pre-entry value minus 4.
- R7: A hardware entry writes the acknowledged level (returned bits 14:12) to the priority level. A software entry leaves the priority level untouched.
- R8: The block makes two vector reads: first at VEC_BASE + 4*number, then at that address + 2. The PC is then loaded with {second word[3:0], first word}, in the same cycle as `done`.
- R9: Bus reads and writes never overlap. The bus is silent while idle. Both stack writes come before the first vector read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_done | input | 1 | Current instruction completes this cycle |
| insn_pausable | input | 1 | A pausable instruction is executing |
| hw_req | input | 1 | Hardware request pending |
| hw_lvl | input | 3 | Level of the pending hardware request |
| sw_req | input | 1 | Software interrupt instruction completes this cycle |
| sw_num | input | 6 | Number given by the software interrupt instruction |
| cpu_flg | input | 12 | Current flag register |
| cpu_pc | input | 20 | Current program counter (return address) |
| cpu_sp | input | 16 | Current stack pointer |
| cpu_ipl | input | 3 | Current priority level |
| bus_rdata | input | 16 | Read data, valid in the cycle of the read strobe |
| bus_addr | output | 20 | Bus address |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | 16 | Write data |
| flg_we | output | 1 | Flag register write enable |
| flg_wdata | output | 12 | New flag value |
| pc_we | output | 1 | Program counter write enable |
| pc_wdata | output | 20 | Handler start address |
| sp_we | output | 1 | Stack pointer write enable |
| sp_wdata | output | 16 | New stack pointer |
| ipl_we | output | 1 | Priority level write enable |
| ipl_wdata | output | 3 | New priority level |
| ack_clr | output | 1 | Clear the acknowledged source's request |
| ack_num | output | 6 | Number of the source to clear |
| busy | output | 1 | Entry sequence in progress |
| done | output | 1 | Handler address loaded this cycle |

## Verification
The assertions watch, on every cycle, that the bus never reads and writes at once and stays quiet while idle. They also check that an acknowledge pulse always rides on a read of address zero, that any flag write has the enable and single-step bits cleared, and that the stack pointer drops by exactly four. A counter in the checker confirms that `done` arrives in the eighteenth busy cycle and that `busy` falls right after it.

Some behaviour is only visible through the bench's scenarios:
- which requests are accepted or refused at the level and enable boundaries;
- whether the stack-select flag is kept at software numbers 31 versus 32;
- the exact stack and vector addresses and data, and their order;
- the final program counter and priority level.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  parameter int ADDR_W = 20;
  parameter int DATA_W = 16;
  parameter int FLG_W  = 12;
  parameter int SP_W   = 16;
  parameter int NUM_W  = 6;
  parameter int LVL_W  = 3;
  parameter int PCHI_W = ADDR_W - DATA_W;

  // flag bit positions
  parameter int FB_STEP = 2;
  parameter int FB_IEN  = 6;
  parameter int FB_STK  = 7;

  // acknowledge word fields
  parameter int ACK_NUM_LSB = 0;
  parameter int ACK_LVL_LSB = 12;

  // sequence script (step index inside the busy window)
  parameter int SEQ_LEN   = 18;
  parameter int STEP_W    = $clog2(SEQ_LEN);
  parameter int ST_ACK    = 1;
  parameter int ST_SNAP   = 2;
  parameter int ST_PUSH_F = 4;
  parameter int ST_PUSH_P = 6;
  parameter int ST_SPUPD  = 7;
  parameter int ST_LVL    = 8;
  parameter int ST_VLO    = 10;
  parameter int ST_VHI    = 13;
  parameter int ST_LAST   = SEQ_LEN - 1;

  function automatic logic [ADDR_W-1:0] vec_addr(input logic [ADDR_W-1:0] base,
                                                 input logic [NUM_W-1:0] num);
    return base + ADDR_W'({num, 2'b00});
  endfunction

  function automatic logic [ADDR_W-1:0] stack_addr(input logic [SP_W-1:0] sp,
                                                   input logic [SP_W-1:0] off);
    logic [SP_W-1:0] a;
    a = sp - off;
    return {{(ADDR_W-SP_W){1'b0}}, a};
  endfunction

  function automatic logic [FLG_W-1:0] entry_flags(input logic [FLG_W-1:0] f,
                                                   input logic keep_stk);
    logic [FLG_W-1:0] r;
    r = f;
    r[FB_IEN]  = 1'b0;
    r[FB_STEP] = 1'b0;
    if (!keep_stk) r[FB_STK] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/irq_accept_gate.sv
module irq_accept_gate
  import irq_entry_pkg::*;
(
  input  logic             idle,
  input  logic             insn_done,
  input  logic             insn_pausable,
  input  logic             hw_req,
  input  logic [LVL_W-1:0] hw_lvl,
  input  logic             sw_req,
  input  logic [NUM_W-1:0] sw_num,
  input  logic             flg_ien,
  input  logic [LVL_W-1:0] cpu_ipl,
  output logic             take,
  output logic             take_sw,
  output logic [NUM_W-1:0] take_num
);
  logic hw_ok, sw_ok, window;

  always_comb begin
    window   = insn_done || insn_pausable;
    hw_ok    = hw_req && flg_ien && (hw_lvl > cpu_ipl) && window;
    sw_ok    = sw_req && insn_done;
    take     = idle && (hw_ok || sw_ok);
    take_sw  = sw_ok;
    take_num = sw_ok ? sw_num : '0;
  end
endmodule

// File: rtl/irq_step_ctr.sv
module irq_step_ctr
  import irq_entry_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic [STEP_W-1:0] step
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      step <= '0;
    end else if (start) begin
      busy <= 1'b1;
      step <= '0;
    end else if (busy) begin
      if (step == STEP_W'(ST_LAST)) begin
        busy <= 1'b0;
        step <= '0;
      end else begin
        step <= step + STEP_W'(1);
      end
    end
  end
endmodule

// File: rtl/irq_entry_datapath.sv
module irq_entry_datapath
  import irq_entry_pkg::*;
#(
  parameter logic [ADDR_W-1:0] VEC_BASE = 20'hFF000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              take_sw,
  input  logic [NUM_W-1:0]  take_num,
  input  logic              ev_ack,
  input  logic              ev_snap,
  input  logic              ev_push_f,
  input  logic              ev_push_p,
  input  logic              ev_spupd,
  input  logic              ev_lvl,
  input  logic              ev_vlo,
  input  logic              ev_vhi,
  input  logic              ev_last,
  input  logic [FLG_W-1:0]  cpu_flg,
  input  logic [ADDR_W-1:0] cpu_pc,
  input  logic [SP_W-1:0]   cpu_sp,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              flg_we,
  output logic [FLG_W-1:0]  flg_wdata,
  output logic              pc_we,
  output logic [ADDR_W-1:0] pc_wdata,
  output logic              sp_we,
  output logic [SP_W-1:0]   sp_wdata,
  output logic              ipl_we,
  output logic [LVL_W-1:0]  ipl_wdata,
  output logic              ack_clr,
  output logic [NUM_W-1:0]  ack_num
);
  logic              is_sw;
  logic [NUM_W-1:0]  num_q;
  logic [LVL_W-1:0]  lvl_q;
  logic [ADDR_W-1:0] pc_q;
  logic [SP_W-1:0]   sp_q;
  logic [FLG_W-1:0]  tmp_flg;
  logic [DATA_W-1:0] vlo_q;
  logic [PCHI_W-1:0] vhi_q;
  logic [ADDR_W-1:0] vec_a;
  logic              hw_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_sw   <= 1'b0;
      num_q   <= '0;
      lvl_q   <= '0;
      pc_q    <= '0;
      sp_q    <= '0;
      tmp_flg <= '0;
      vlo_q   <= '0;
      vhi_q   <= '0;
    end else begin
      if (take) begin
        is_sw <= take_sw;
        num_q <= take_num;
        pc_q  <= cpu_pc;
        sp_q  <= cpu_sp;
      end
      if (hw_ack) begin
        num_q <= bus_rdata[ACK_NUM_LSB +: NUM_W];
        lvl_q <= bus_rdata[ACK_LVL_LSB +: LVL_W];
      end
      if (ev_snap) tmp_flg <= cpu_flg;
      if (ev_vlo)  vlo_q   <= bus_rdata;
      if (ev_vhi)  vhi_q   <= bus_rdata[PCHI_W-1:0];
    end
  end

  always_comb begin
    hw_ack = ev_ack && !is_sw;
    vec_a  = vec_addr(VEC_BASE, num_q);

    bus_rd = hw_ack || ev_vlo || ev_vhi;
    bus_wr = ev_push_f || ev_push_p;
    if (ev_push_f)      bus_addr = stack_addr(sp_q, SP_W'(2));
    else if (ev_push_p) bus_addr = stack_addr(sp_q, SP_W'(4));
    else if (ev_vlo)    bus_addr = vec_a;
    else if (ev_vhi)    bus_addr = vec_a + ADDR_W'(2);
    else                bus_addr = '0;
    bus_wdata = ev_push_f ? {pc_q[ADDR_W-1:DATA_W], tmp_flg} : pc_q[DATA_W-1:0];

    flg_we    = ev_snap;
    flg_wdata = entry_flags(cpu_flg, is_sw && num_q[NUM_W-1]);
    sp_we     = ev_spupd;
    sp_wdata  = sp_q - SP_W'(4);
    ipl_we    = ev_lvl && !is_sw;
    ipl_wdata = lvl_q;
    pc_we     = ev_last;
    pc_wdata  = {vhi_q, vlo_q};
    ack_clr   = hw_ack;
    ack_num   = bus_rdata[ACK_NUM_LSB +: NUM_W];
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter logic [ADDR_W-1:0] VEC_BASE = 20'hFF000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_done,
  input  logic              insn_pausable,
  input  logic              hw_req,
  input  logic [LVL_W-1:0]  hw_lvl,
  input  logic              sw_req,
  input  logic [NUM_W-1:0]  sw_num,
  input  logic [FLG_W-1:0]  cpu_flg,
  input  logic [ADDR_W-1:0] cpu_pc,
  input  logic [SP_W-1:0]   cpu_sp,
  input  logic [LVL_W-1:0]  cpu_ipl,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              flg_we,
  output logic [FLG_W-1:0]  flg_wdata,
  output logic              pc_we,
  output logic [ADDR_W-1:0] pc_wdata,
  output logic              sp_we,
  output logic [SP_W-1:0]   sp_wdata,
  output logic              ipl_we,
  output logic [LVL_W-1:0]  ipl_wdata,
  output logic              ack_clr,
  output logic [NUM_W-1:0]  ack_num,
  output logic              busy,
  output logic              done
);
  logic              take, take_sw;
  logic [NUM_W-1:0]  take_num;
  logic [STEP_W-1:0] step;
  logic ev_ack, ev_snap, ev_push_f, ev_push_p, ev_spupd, ev_lvl, ev_vlo, ev_vhi, ev_last;

  irq_accept_gate u_gate (
    .idle(!busy), .insn_done(insn_done), .insn_pausable(insn_pausable),
    .hw_req(hw_req), .hw_lvl(hw_lvl), .sw_req(sw_req), .sw_num(sw_num),
    .flg_ien(cpu_flg[FB_IEN]), .cpu_ipl(cpu_ipl),
    .take(take), .take_sw(take_sw), .take_num(take_num)
  );

  irq_step_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .start(take), .busy(busy), .step(step)
  );

  // named step events of the entry script
  always_comb begin
    ev_ack    = busy && (step == STEP_W'(ST_ACK));
    ev_snap   = busy && (step == STEP_W'(ST_SNAP));
    ev_push_f = busy && (step == STEP_W'(ST_PUSH_F));
    ev_push_p = busy && (step == STEP_W'(ST_PUSH_P));
    ev_spupd  = busy && (step == STEP_W'(ST_SPUPD));
    ev_lvl    = busy && (step == STEP_W'(ST_LVL));
    ev_vlo    = busy && (step == STEP_W'(ST_VLO));
    ev_vhi    = busy && (step == STEP_W'(ST_VHI));
    ev_last   = busy && (step == STEP_W'(ST_LAST));
    done      = ev_last;
  end

  irq_entry_datapath #(.VEC_BASE(VEC_BASE)) u_dp (
    .clk(clk), .rst_n(rst_n), .take(take), .take_sw(take_sw), .take_num(take_num),
    .ev_ack(ev_ack), .ev_snap(ev_snap), .ev_push_f(ev_push_f), .ev_push_p(ev_push_p),
    .ev_spupd(ev_spupd), .ev_lvl(ev_lvl), .ev_vlo(ev_vlo), .ev_vhi(ev_vhi),
    .ev_last(ev_last), .cpu_flg(cpu_flg), .cpu_pc(cpu_pc), .cpu_sp(cpu_sp),
    .bus_rdata(bus_rdata), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .flg_we(flg_we), .flg_wdata(flg_wdata), .pc_we(pc_we),
    .pc_wdata(pc_wdata), .sp_we(sp_we), .sp_wdata(sp_wdata), .ipl_we(ipl_we),
    .ipl_wdata(ipl_wdata), .ack_clr(ack_clr), .ack_num(ack_num)
  );
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk
  import irq_entry_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              ack_clr,
  input logic              flg_we,
  input logic [FLG_W-1:0]  flg_wdata,
  input logic              sp_we,
  input logic [SP_W-1:0]   sp_wdata,
  input logic [SP_W-1:0]   cpu_sp
);
  logic [STEP_W-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)    busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + STEP_W'(1);
    else           busy_cnt <= '0;
  end

  AST_DONE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy && busy_cnt == STEP_W'(SEQ_LEN-1))); // R2
  AST_DONE_END: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R2
  AST_RDWR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr)); // R9
  AST_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_rd && !bus_wr)); // R9
  AST_ACK_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    ack_clr |-> (bus_rd && bus_addr == '0)); // R3
  AST_FLG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    flg_we |-> (!flg_wdata[FB_IEN] && !flg_wdata[FB_STEP])); // R4
  AST_SP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    sp_we |-> (sp_wdata == cpu_sp - SP_W'(4))); // R6
endmodule

bind irq_entry_seq irq_entry_chk chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .bus_rd(bus_rd),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .ack_clr(ack_clr), .flg_we(flg_we),
  .flg_wdata(flg_wdata), .sp_we(sp_we), .sp_wdata(sp_wdata), .cpu_sp(cpu_sp)
);

// File: tb/irq_entry_seq_tb_top.sv
module irq_entry_seq_tb_top;
  localparam logic [19:0] VBASE = 20'hFF000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic insn_done = 0, insn_pausable = 0, hw_req = 0, sw_req = 0;
  logic [2:0] hw_lvl = '0;
  logic [5:0] sw_num = '0;
  logic [11:0] m_flg;
  logic [19:0] m_pc;
  logic [15:0] m_sp;
  logic [2:0]  m_ipl;
  logic [15:0] bus_rdata, ack_word = '0;
  logic [19:0] bus_addr, pc_wdata;
  logic bus_rd, bus_wr, flg_we, pc_we, sp_we, ipl_we, ack_clr, busy, done;
  logic [15:0] bus_wdata, sp_wdata;
  logic [11:0] flg_wdata;
  logic [2:0]  ipl_wdata;
  logic [5:0]  ack_num;

  logic ld = 0;
  logic [11:0] ld_flg = '0;
  logic [19:0] ld_pc = '0;
  logic [15:0] ld_sp = '0;
  logic [2:0]  ld_ipl = '0;

  irq_entry_seq #(.VEC_BASE(VBASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .insn_pausable(insn_pausable),
    .hw_req(hw_req), .hw_lvl(hw_lvl), .sw_req(sw_req), .sw_num(sw_num),
    .cpu_flg(m_flg), .cpu_pc(m_pc), .cpu_sp(m_sp), .cpu_ipl(m_ipl),
    .bus_rdata(bus_rdata), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .flg_we(flg_we), .flg_wdata(flg_wdata), .pc_we(pc_we),
    .pc_wdata(pc_wdata), .sp_we(sp_we), .sp_wdata(sp_wdata), .ipl_we(ipl_we),
    .ipl_wdata(ipl_wdata), .ack_clr(ack_clr), .ack_num(ack_num), .busy(busy), .done(done)
  );

  // register model
  always @(posedge clk) begin
    if (ld) begin
      m_flg <= ld_flg; m_pc <= ld_pc; m_sp <= ld_sp; m_ipl <= ld_ipl;
    end else begin
      if (flg_we) m_flg <= flg_wdata;
      if (pc_we)  m_pc  <= pc_wdata;
      if (sp_we)  m_sp  <= sp_wdata;
      if (ipl_we) m_ipl <= ipl_wdata;
    end
  end

  // memory model: ack word at 0, vector table above VBASE
  always_comb begin
    logic [19:0] off;
    off = bus_addr - VBASE;
    if (bus_addr == 20'h0)     bus_rdata = ack_word;
    else if (bus_addr >= VBASE) bus_rdata = off[1] ? (16'hABC0 | 16'(off[5:2] & 4'hF))
                                                   : (16'hA000 + 16'(off[7:2]));
    else                        bus_rdata = 16'h0;
  end

  int n_chk = 0, n_err = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // capture record
  int nbusy, done_at, nrd, nwr, nack, nflg, nipl, nsp;
  logic [19:0] rd_a [8];
  int          rd_i [8];
  logic [19:0] wr_a [8];
  logic [15:0] wr_d [8];
  int          wr_i [8];
  logic [5:0]  ack_n;

  task automatic capture(input int ncyc);
    nbusy = 0; done_at = -1; nrd = 0; nwr = 0; nack = 0; nflg = 0; nipl = 0; nsp = 0;
    for (int i = 0; i < ncyc; i++) begin
      if (busy) nbusy++;
      if (done) done_at = nbusy;
      if (bus_rd && nrd < 8) begin rd_a[nrd] = bus_addr; rd_i[nrd] = i; nrd++; end
      if (bus_wr && nwr < 8) begin wr_a[nwr] = bus_addr; wr_d[nwr] = bus_wdata; wr_i[nwr] = i; nwr++; end
      if (ack_clr) begin nack++; ack_n = ack_num; end
      if (flg_we) nflg++;
      if (ipl_we) nipl++;
      if (sp_we)  nsp++;
      @(negedge clk);
    end
  endtask

  task automatic preset(input logic [11:0] f, input logic [19:0] p,
                        input logic [15:0] s, input logic [2:0] l);
    ld_flg = f; ld_pc = p; ld_sp = s; ld_ipl = l; ld = 1;
    @(negedge clk);
    ld = 0;
    @(negedge clk);
  endtask

  // drive one request cycle, then record
  task automatic fire(input bit hw, input bit sw, input bit bnd, input bit pau,
                      input logic [2:0] lvl, input logic [5:0] n, input int ncyc);
    hw_req = hw; sw_req = sw; insn_done = bnd; insn_pausable = pau;
    hw_lvl = lvl; sw_num = n;
    ack_word = {1'b0, lvl, 6'b101010, n};
    @(negedge clk);
    hw_req = 0; sw_req = 0; insn_done = 0; insn_pausable = 0;
    capture(ncyc);
  endtask

  task automatic check_entry(input bit is_sw, input logic [5:0] n, input logic [2:0] lvl,
                             input logic [11:0] f0, input logic [19:0] p0,
                             input logic [15:0] s0, input logic [2:0] l0);
    logic [11:0] fexp;
    logic [19:0] va;
    int vr;
    fexp = f0;
    fexp[6] = 1'b0; fexp[2] = 1'b0;
    if (!(is_sw && n >= 32)) fexp[7] = 1'b0;
    va = VBASE + 20'(n) * 4;
    vr = is_sw ? 0 : 1;
    chk(nbusy == 18, "R2", "busy length", nbusy, 18);
    chk(done_at == 18, "R2", "done position", done_at, 18);
    if (is_sw) begin
      chk(nack == 0 && nrd == 2, "R3", "sw ack reads", nrd, 2);
    end else begin
      chk(nrd == 3 && rd_a[0] == 20'h0, "R3", "ack read addr", rd_a[0], 0);
      chk(nack == 1 && ack_n == n, "R3", "ack number", ack_n, n);
    end
    chk(nflg == 1 && m_flg == fexp, is_sw ? "R5" : "R4", "flags", m_flg, fexp);
    chk(nwr == 2 && wr_a[0] == {4'h0, s0 - 16'd2}, "R6", "push1 addr", wr_a[0], {4'h0, s0 - 16'd2});
    chk(wr_d[0] == {p0[19:16], f0}, "R6", "push1 data", wr_d[0], {p0[19:16], f0});
    chk(wr_a[1] == {4'h0, s0 - 16'd4} && wr_d[1] == p0[15:0], "R6", "push2", wr_d[1], p0[15:0]);
    chk(m_sp == s0 - 16'd4 && nsp == 1, "R6", "sp", m_sp, s0 - 16'd4);
    chk(rd_a[vr] == va && rd_a[vr+1] == va + 20'd2, "R8", "vector addrs", rd_a[vr], va);
    chk(m_pc == {n[3:0], 16'hA000 + 16'(n)}, "R8", "pc", m_pc, {n[3:0], 16'hA000 + 16'(n)});
    chk(wr_i[1] < rd_i[vr], "R9", "writes before vector", wr_i[1], rd_i[vr]);
    if (is_sw) chk(nipl == 0 && m_ipl == l0, "R7", "ipl kept", m_ipl, l0);
    else       chk(nipl == 1 && m_ipl == lvl, "R7", "ipl set", m_ipl, lvl);
  endtask

  task automatic t_reset();
    chk(busy == 0 && done == 0, "R2", "reset busy", busy, 0);
    chk(bus_rd == 0 && bus_wr == 0, "R9", "reset bus", {bus_rd, bus_wr}, 0);
  endtask

  task automatic t_hw_basic();
    preset(12'h2C5, 20'h34567, 16'h0800, 3'd2);
    fire(1, 0, 1, 0, 3'd5, 6'd10, 24);
    check_entry(0, 6'd10, 3'd5, 12'h2C5, 20'h34567, 16'h0800, 3'd2);
  endtask

  task automatic t_hw_pausable();
    preset(12'h040, 20'hF1234, 16'h1000, 3'd0);
    fire(1, 0, 0, 1, 3'd1, 6'd63, 24);
    chk(nbusy == 18, "R1", "accept mid-instruction", nbusy, 18);
    check_entry(0, 6'd63, 3'd1, 12'h040, 20'hF1234, 16'h1000, 3'd0);
  endtask

  task automatic t_reject(input logic [11:0] f, input logic [2:0] ipl,
                          input logic [2:0] lvl, input bit bnd, input string what);
    preset(f, 20'h00100, 16'h0400, ipl);
    fire(1, 0, bnd, 0, lvl, 6'd7, 6);
    chk(nbusy == 0 && nrd == 0 && nwr == 0, "R1", what, nbusy, 0);
    chk(m_pc == 20'h00100 && m_sp == 16'h0400, "R1", {what, " regs"}, m_pc, 20'h00100);
  endtask

  task automatic t_sw(input logic [5:0] n, input logic [11:0] f);
    preset(f, 20'h2ABCD, 16'h0C00, 3'd4);
    fire(0, 1, 1, 0, 3'd0, n, 24);
    check_entry(1, n, 3'd0, f, 20'h2ABCD, 16'h0C00, 3'd4);
  endtask

  task automatic t_both();
    preset(12'h0C0, 20'h00200, 16'h0900, 3'd0);
    fire(1, 1, 1, 0, 3'd6, 6'd33, 24);
    chk(nack == 0 && nrd == 2, "R1", "software wins", nack, 0);
    chk(m_ipl == 3'd0, "R7", "ipl untouched", m_ipl, 0);
  endtask

  task automatic t_no_reaccept();
    preset(12'h040, 20'h00300, 16'h0A00, 3'd0);
    hw_req = 1; insn_done = 1; hw_lvl = 3'd3; ack_word = {1'b0, 3'd3, 6'd0, 6'd4};
    @(negedge clk);
    capture(24);  // request held high through the whole entry
    hw_req = 0; insn_done = 0;
    chk(nack == 1 && nbusy == 18, "R2", "no accept while busy", nack, 1);
  endtask

  bit fin = 0;
  initial begin
    #(200000 * 5ns);
    if (!fin) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_hw_basic();
    t_hw_pausable();
    t_reject(12'h000, 3'd1, 3'd5, 1, "enable clear blocks");
    t_reject(12'h040, 3'd5, 3'd5, 1, "equal level blocks");
    t_reject(12'h040, 3'd1, 3'd5, 0, "no boundary blocks");
    t_sw(6'd31, 12'h084);  // R5: 31 clears stack flag
    t_sw(6'd32, 12'h084);  // R5: 32 keeps it
    t_sw(6'd5, 12'h000);   // R1: accepted with enable clear
    t_both();
    t_no_reaccept();
    fin = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule